// File: doc/BRIEF.md
# Planar Color-Compare Read Unit

This unit sits beside a four-plane bitmap graphics engine. It holds the engine's control registers and answers CPU reads of video memory. On each read it is given the words of all four video-memory banks at the addressed location. It then returns one of two things: the word of a single plane, or a color-compare word. In the compare word a bit is set only where every plane agrees with a 16-bit pattern word built for that plane.

The pattern word for each plane comes from one of three sources. It can be the foreground color, the background color, or a per-plane pattern latch that is captured from video memory on request. A color is expanded into pattern words by copying its bit for each plane across the whole word. The unit also hands the blitter its plane write enables, its bit offsets and a transfer length that is reloaded whenever the length or offset register is written.

Top module: `plane_cmp_unit`

## Requirements
- R1: After reset all eight registers, the pattern latches and the flags are zero. So rd_data=0, rd_valid=0, xfer_count=0, src_shift=0, dst_shift=0, init_done=0 and plane_wr_en=4'hF.
- R2: A register write to address reg_addr updates only the bytes whose reg_be bit is set: bit 0 controls bits 7:0 and bit 1 controls bits 15:8.
- R3: rd_valid is high for exactly the cycle after each cycle with rd_req high, and rd_data then carries the result. Without rd_req, rd_data holds its value.
- R4: When register 2 bit 13 is 0, a read returns the word of plane s, where s is register 1 bits 9:8. Plane i is taken from bank (i+1) mod 4, and bank b is vram_rdata[16b+15:16b], so plane 3 comes from bank 0.
- R5: When register 2 bit 13 is 1, a read returns the AND over the four planes of the XNOR of each plane's pattern word with that plane's word.
- R6: When register 1 bits 14:13 equal 2, plane i's pattern is 16'hFFFF if bit i of register 3 is 1 and 16'h0000 otherwise.
- R7: When register 1 bits 14:13 equal 1, the pattern is built the same way from register 5.
- R8: When register 1 bits 14:13 equal 0 or 3, the per-plane pattern latches are used. A read with register 1 bit 12 set captures all four plane words into them, and that same read still compares against the old latch contents.
- R9: A write to register 6 or 7 loads xfer_count with register 7 bits 11:0 (after the write) plus one, as a 13-bit value.
- R10: src_shift is register 6 bits 3:0 and dst_shift is register 6 bits 7:4.
- R11: Bit i of plane_wr_en is the inverse of bit i of register 0.
- R12: init_done is set by the first read and stays set until reset.
- R13: A register write and a read in the same cycle: the read result is formed from the register values before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index 0..7 |
| reg_be | input | 2 | Byte enables for the register write |
| reg_wdata | input | 16 | Register write data |
| rd_req | input | 1 | CPU read strobe |
| vram_rdata | input | 4*W | Words of the four video-memory banks, bank b in bits 16b+15:16b |
| rd_data | output | W | Registered read result |
| rd_valid | output | 1 | rd_data is new this cycle |
| plane_wr_en | output | 4 | Per-plane write enable for the blitter |
| src_shift | output | 4 | Source bit offset |
| dst_shift | output | 4 | Destination bit offset |
| xfer_count | output | CNTW+1 | Transfer length |
| init_done | output | 1 | A read has occurred since reset |

## Verification
Two things can happen in the same cycle: a register write and a read. The read can also carry a pattern capture while it compares. The bench issues a register-1 write together with rd_req and checks that the returned plane follows the old select field, while the next read follows the new one. It also issues a capturing compare read and checks that this read compares against the previous latch contents, while the following read compares against the captured words.

// File: rtl/plane_cmp_unit.sv
module plane_cmp_unit #(
  parameter int W    = 16,
  parameter int CNTW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [1:0]        reg_be,
  input  logic [15:0]       reg_wdata,
  input  logic              rd_req,
  input  logic [4*W-1:0]    vram_rdata,
  output logic [W-1:0]      rd_data,
  output logic              rd_valid,
  output logic [3:0]        plane_wr_en,
  output logic [3:0]        src_shift,
  output logic [3:0]        dst_shift,
  output logic [CNTW:0]     xfer_count,
  output logic              init_done
);

  logic [15:0]  regs [8];
  logic [15:0]  wmerged;
  logic [W-1:0] pw   [4];
  logic [W-1:0] pat  [4];
  logic [W-1:0] patl [4];
  logic [W-1:0] cmp;
  logic [CNTW-1:0] len_next;

  always_comb begin
    wmerged = regs[reg_addr];
    if (reg_be[0]) wmerged[7:0]  = reg_wdata[7:0];
    if (reg_be[1]) wmerged[15:8] = reg_wdata[15:8];
  end

  assign len_next = (reg_addr == 3'd7) ? wmerged[CNTW-1:0] : regs[7][CNTW-1:0];

  for (genvar i = 0; i < 4; i++) begin : g_plane
    assign pw[i] = vram_rdata[W*((i+1)%4) +: W];
    always_comb begin
      case (regs[1][14:13])
        2'd1:    pat[i] = {W{regs[5][i]}};
        2'd2:    pat[i] = {W{regs[3][i]}};
        default: pat[i] = patl[i];
      endcase
    end
  end

  assign cmp = ~(pat[0] ^ pw[0]) & ~(pat[1] ^ pw[1]) &
               ~(pat[2] ^ pw[2]) & ~(pat[3] ^ pw[3]);

  assign plane_wr_en = ~regs[0][3:0];
  assign src_shift   = regs[6][3:0];
  assign dst_shift   = regs[6][7:4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) regs[k] <= '0;
      for (int k = 0; k < 4; k++) patl[k] <= '0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      xfer_count <= '0;
      init_done  <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (reg_we) begin
        regs[reg_addr] <= wmerged;
        if (reg_addr == 3'd6 || reg_addr == 3'd7)
          xfer_count <= {1'b0, len_next} + 1'b1;
      end
      if (rd_req) begin
        init_done <= 1'b1;
        rd_data   <= regs[2][13] ? cmp : pw[regs[1][9:8]];
        if (regs[1][12])
          for (int k = 0; k < 4; k++) patl[k] <= pw[k];
      end
    end
  end

endmodule

// File: rtl/plane_cmp_chk.sv
module plane_cmp_chk #(
  parameter int W    = 16,
  parameter int CNTW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic [1:0]    reg_be,
  input logic [15:0]   reg_wdata,
  input logic          rd_req,
  input logic [W-1:0]  rd_data,
  input logic          rd_valid,
  input logic [3:0]    plane_wr_en,
  input logic [3:0]    src_shift,
  input logic [3:0]    dst_shift,
  input logic [CNTW:0] xfer_count,
  input logic          init_done
);

  // R3
  rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  // R3
  rd_valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_data));
  // R12
  init_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> init_done);
  // R12
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  // R9
  xfer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd7 && reg_be == 2'b11) |=>
      xfer_count == {1'b0, $past(reg_wdata[CNTW-1:0])} + 1'b1);
  // R11
  plane_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && reg_be[0]) |=>
      plane_wr_en == ~$past(reg_wdata[3:0]));
  // R10
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd6 && reg_be[0]) |=>
      (src_shift == $past(reg_wdata[3:0]) && dst_shift == $past(reg_wdata[7:4])));

endmodule

bind plane_cmp_unit plane_cmp_chk #(.W(W), .CNTW(CNTW)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_be(reg_be), .reg_wdata(reg_wdata), .rd_req(rd_req),
  .rd_data(rd_data), .rd_valid(rd_valid), .plane_wr_en(plane_wr_en),
  .src_shift(src_shift), .dst_shift(dst_shift), .xfer_count(xfer_count),
  .init_done(init_done)
);

// File: tb/test_plane_cmp_unit.sv
`timescale 1ns/1ps
module test_plane_cmp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [1:0]  reg_be = '0;
  logic [15:0] reg_wdata = '0;
  logic        rd_req = 1'b0;
  logic [63:0] vram_rdata = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [3:0]  plane_wr_en, src_shift, dst_shift;
  logic [12:0] xfer_count;
  logic        init_done;

  int checks = 0;
  int fails  = 0;
  logic [15:0] sh [8];
  logic [3:0][15:0] lp;

  always #2 clk = ~clk;

  plane_cmp_unit i_plane_cmp_unit (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] plw(input logic [63:0] v, input int i);
    return v[16*((i+1)%4) +: 16];
  endfunction

  function automatic logic [15:0] epat(input int i);
    case (sh[1][14:13])
      2'd1:    return {16{sh[5][i]}};
      2'd2:    return {16{sh[3][i]}};
      default: return lp[i];
    endcase
  endfunction

  function automatic logic [15:0] ecmp(input logic [63:0] v);
    logic [15:0] r = '1;
    for (int i = 0; i < 4; i++) r &= ~(epat(i) ^ plw(v, i));
    return r;
  endfunction

  function automatic logic [15:0] eread(input logic [63:0] v);
    return sh[2][13] ? ecmp(v) : plw(v, int'(sh[1][9:8]));
  endfunction

  task automatic wr(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
    if (be[0]) sh[a][7:0]  = d[7:0];
    if (be[1]) sh[a][15:8] = d[15:8];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [63:0] v, input string req);
    logic [15:0] e;
    e = eread(v);
    @(negedge clk);
    rd_req = 1'b1; vram_rdata = v;
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_valid === 1'b1, "R3 valid", {31'b0, rd_valid}, 1);
    chk(rd_data === e, req, rd_data, e);
    if (sh[1][12]) for (int i = 0; i < 4; i++) lp[i] = plw(v, i);
  endtask

  task automatic t_reset;
    chk(rd_data === 16'h0 && rd_valid === 1'b0, "R1 read outs", {rd_data, 15'b0, rd_valid}, 0);
    chk(xfer_count === 13'h0, "R1 count", xfer_count, 0);
    chk(src_shift === 4'h0 && dst_shift === 4'h0, "R1 shifts", {dst_shift, src_shift}, 0);
    chk(plane_wr_en === 4'hF, "R1 planes", plane_wr_en, 4'hF);
    chk(init_done === 1'b0, "R1 R12 init", init_done, 0);
  endtask

  task automatic t_regs;
    wr(3'd6, 2'b11, 16'h00A5);
    chk(xfer_count === 13'd1, "R9 reg6 load", xfer_count, 1);
    chk(src_shift === 4'h5 && dst_shift === 4'hA, "R10 shifts", {dst_shift, src_shift}, 8'hA5);
    wr(3'd6, 2'b10, 16'hFFFF);
    chk(src_shift === 4'h5 && dst_shift === 4'hA, "R2 high byte only", {dst_shift, src_shift}, 8'hA5);
    wr(3'd7, 2'b11, 16'h0123);
    chk(xfer_count === 13'h124, "R9 reg7 load", xfer_count, 13'h124);
    wr(3'd7, 2'b11, 16'hFFFF);
    chk(xfer_count === 13'h1000, "R9 max length", xfer_count, 13'h1000);
    wr(3'd7, 2'b01, 16'h00AB);
    chk(xfer_count === 13'hFAC, "R2 R9 low byte", xfer_count, 13'hFAC);
    wr(3'd0, 2'b11, 16'h0005);
    chk(plane_wr_en === 4'b1010, "R11 plane enables", plane_wr_en, 4'b1010);
  endtask

  task automatic t_source;
    logic [63:0] v = 64'h4444_3333_2222_1111;
    for (int s = 0; s < 4; s++) begin
      wr(3'd1, 2'b11, 16'(s << 8));
      rd(v, "R4 plane select");
      chk(init_done === 1'b1, "R12 init set", init_done, 1);
    end
    @(negedge clk);
    chk(rd_valid === 1'b0 && rd_data === plw(v, 3), "R3 hold", {rd_data, 15'b0, rd_valid}, {plw(v, 3), 16'h0});
  endtask

  task automatic t_colors;
    logic [63:0] v = 64'hF0F0_CCCC_FF00_AAAA;
    wr(3'd2, 2'b11, 16'h2000);
    wr(3'd3, 2'b11, 16'h000A);
    wr(3'd5, 2'b11, 16'h0006);
    wr(3'd1, 2'b11, 16'h4000);
    rd(v, "R5 R6 fore compare");
    rd(64'h0, "R6 fore zero vram");
    wr(3'd1, 2'b11, 16'h2000);
    rd(v, "R5 R7 back compare");
    rd(64'hFFFF_0000_FFFF_FFFF, "R7 back compare 2");
  endtask

  task automatic t_latched;
    logic [63:0] v1 = 64'h1234_5678_9ABC_DEF0;
    logic [63:0] v2 = 64'h1234_5678_9ABC_DE0F;
    wr(3'd1, 2'b11, 16'h1000);
    rd(v1, "R8 capture uses old latch");
    wr(3'd1, 2'b11, 16'h0000);
    rd(v2, "R8 latched pattern");
    wr(3'd1, 2'b11, 16'h6000);
    rd(v1, "R8 field 3 latched");
  endtask

  task automatic t_collide;
    logic [63:0] v = 64'hDDDD_CCCC_BBBB_AAAA;
    wr(3'd2, 2'b11, 16'h0000);
    wr(3'd1, 2'b11, 16'h0100);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd1; reg_be = 2'b11; reg_wdata = 16'h0200;
    rd_req = 1'b1; vram_rdata = v;
    @(negedge clk);
    reg_we = 1'b0; rd_req = 1'b0;
    chk(rd_data === plw(v, 1), "R13 old select", rd_data, plw(v, 1));
    sh[1] = 16'h0200;
    rd(v, "R13 new select");
  endtask

  initial begin
    #400000;
    $display("FAIL watchdog expired");
    fails++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) sh[k] = '0;
    lp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_source();
    t_colors();
    t_latched();
    t_collide();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule